// File: doc/BRIEF.md
# Bit-Sliced Hit Word Lane Serializer

This block takes a group of parallel hit words, one group per frame, and sends them out over a set of serial lanes. Lane k carries bit k of every word in the group, so each lane is a one-bit-wide slice of the whole group. A group is captured in one cycle of the fast shift clock. The group is then sent out one word position per cycle, word 0 first. A frame marker output is high during the first bit period of each frame.

The slow frame clock and the fast shift clock are treated as one fast clock. The frame boundary is a load strobe that upstream logic asserts once every WORDS cycles. With the defaults there are eight 13-bit words and 13 lanes, so each lane sends eight bits per frame. Frames follow each other with no idle bit between them.

The group on the word input is sampled only at the edge where the load strobe is high. That group appears on the lanes in the following frame.

Top module: `hitword_lane_serializer`

## Requirements
- R1: After reset, and until the first load strobe is sampled, every lane and the frame marker are 0.
- R2: In the first bit period after the edge that samples a load strobe, lane k equals bit k of word 0. Word j occupies bits [j*BITS +: BITS] of `words_in`.
- R3: In the j-th bit period after a load (j = 0..WORDS-1), lane k carries bit k of word j. As a result, the lane vector equals word j.
- R4: `frame_sync` is 1 in the bit period right after each load and 0 in every other period.
- R5: With a load every WORDS cycles, the frames follow each other with no gap and no repeated bit.
- R6: Changes on `words_in` while the load strobe is low have no effect on the bits being sent.
- R7: If no new load arrives after WORDS bit periods, all lanes send 0 and the marker stays low until the next load.
- R8: A load that arrives before the current frame has finished drops the rest of that frame. The next period sends word 0 of the new group, with the marker high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast shift clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_en | input | 1 | Frame-boundary strobe; captures `words_in` at this edge |
| words_in | input | WORDS*BITS | Group of hit words; word j in bits [j*BITS +: BITS] |
| lane_out | output | BITS | Serial lanes; lane k carries bit k of the words |
| frame_sync | output | 1 | High during the first bit period of a frame |

## Verification
The assertions check on every cycle that:
- each load is followed by word 0 on the lanes with the marker high;
- the marker is low after any cycle without a load;
- nothing but zeros leaves the lanes before the first load or once a frame has run out.

The order of words 1 to WORDS-1 within a frame, back-to-back streaming, the ignoring of word-input changes between loads, and the restart after an early load are shown only by the bench's frame sweeps, which compare every bit period against the word it should carry.

// File: rtl/hls_pkg.sv
`timescale 1ns/1ps
package hls_pkg;
  localparam int unsigned DEF_WORDS = 8;
  localparam int unsigned DEF_BITS  = 13;

  // Width of a counter that can hold 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/hls_rst_sync.sv
`timescale 1ns/1ps
module hls_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/hls_word_transpose.sv
`timescale 1ns/1ps
module hls_word_transpose #(
  parameter int unsigned WORDS = hls_pkg::DEF_WORDS,
  parameter int unsigned BITS  = hls_pkg::DEF_BITS
) (
  input  logic [WORDS*BITS-1:0] words_in,
  output logic [BITS*WORDS-1:0] slices_out  // slice k at [k*WORDS +: WORDS], entry j = word j
);
  for (genvar k = 0; k < BITS; k++) begin : g_lane
    for (genvar j = 0; j < WORDS; j++) begin : g_word
      assign slices_out[k*WORDS + j] = words_in[j*BITS + k];
    end
  end
endmodule

// File: rtl/hls_lane_shifter.sv
`timescale 1ns/1ps
module hls_lane_shifter #(
  parameter int unsigned WORDS = hls_pkg::DEF_WORDS
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             load,
  input  logic [WORDS-1:0] par_in,
  output logic             ser_out
);
  logic [WORDS-1:0] shreg_q;
  logic [WORDS-1:0] shreg_d;

  // Load a fresh slice, otherwise move toward bit 0 and fill with zero
  always_comb begin
    if (load) shreg_d = par_in;
    else      shreg_d = {1'b0, shreg_q[WORDS-1:1]};
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) shreg_q <= '0;
    else         shreg_q <= shreg_d;
  end

  assign ser_out = shreg_q[0];
endmodule

// File: rtl/hls_frame_marker.sv
`timescale 1ns/1ps
module hls_frame_marker (
  input  logic clk,
  input  logic srst_n,
  input  logic load,
  output logic sync_out
);
  logic sync_q;
  logic sync_d;

  always_comb begin
    sync_d = load;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sync_q <= 1'b0;
    else         sync_q <= sync_d;
  end

  assign sync_out = sync_q;
endmodule

// File: rtl/hitword_lane_serializer.sv
`timescale 1ns/1ps
module hitword_lane_serializer #(
  parameter int unsigned WORDS = hls_pkg::DEF_WORDS,
  parameter int unsigned BITS  = hls_pkg::DEF_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [WORDS*BITS-1:0] words_in,
  output logic [BITS-1:0]       lane_out,
  output logic                  frame_sync
);
  localparam int unsigned SLICE_W = BITS * WORDS;

  logic               srst_n;
  logic [SLICE_W-1:0] slices;

  hls_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  hls_word_transpose #(.WORDS(WORDS), .BITS(BITS)) u_tr (
    .words_in   (words_in),
    .slices_out (slices)
  );

  for (genvar k = 0; k < BITS; k++) begin : g_lane
    hls_lane_shifter #(.WORDS(WORDS)) u_sh (
      .clk     (clk),
      .srst_n  (srst_n),
      .load    (load_en),
      .par_in  (slices[k*WORDS +: WORDS]),
      .ser_out (lane_out[k])
    );
  end

  hls_frame_marker u_mark (
    .clk      (clk),
    .srst_n   (srst_n),
    .load     (load_en),
    .sync_out (frame_sync)
  );
endmodule

// File: rtl/hls_checker.sv
`timescale 1ns/1ps
module hls_checker #(
  parameter int unsigned WORDS = hls_pkg::DEF_WORDS,
  parameter int unsigned BITS  = hls_pkg::DEF_BITS
) (
  input logic                  clk,
  input logic                  srst_n,
  input logic                  load_en,
  input logic [WORDS*BITS-1:0] words_in,
  input logic [BITS-1:0]       lane_out,
  input logic                  frame_sync
);
  localparam int unsigned GW = hls_pkg::cnt_width(WORDS);

  logic          seen_load_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      seen_load_q <= 1'b0;
      gap_q       <= GW'(WORDS);
    end else begin
      if (load_en) seen_load_q <= 1'b1;
      if (load_en)                 gap_q <= '0;
      else if (gap_q < GW'(WORDS)) gap_q <= gap_q + 1'b1;
    end
  end

  assert_quiet_before_load_R1: assert property (@(posedge clk) disable iff (!srst_n)
    !seen_load_q |-> (lane_out == '0 && !frame_sync));

  assert_word0_after_load_R2: assert property (@(posedge clk) disable iff (!srst_n)
    load_en |=> lane_out == $past(words_in[BITS-1:0]));

  assert_sync_after_load_R4: assert property (@(posedge clk) disable iff (!srst_n)
    load_en |=> frame_sync);

  assert_sync_idle_R4: assert property (@(posedge clk) disable iff (!srst_n)
    !load_en |=> !frame_sync);

  assert_drained_zero_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (gap_q == GW'(WORDS)) |-> (lane_out == '0 && !frame_sync));
endmodule

bind hitword_lane_serializer hls_checker #(.WORDS(WORDS), .BITS(BITS)) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .load_en    (load_en),
  .words_in   (words_in),
  .lane_out   (lane_out),
  .frame_sync (frame_sync)
);

// File: tb/tb_hitword_lane_serializer.sv
`timescale 1ns/1ps
module tb_hitword_lane_serializer;
  localparam int WORDS = 8;
  localparam int BITS  = 13;

  logic                  clk;
  logic                  rst_n;
  logic                  load_en;
  logic [WORDS*BITS-1:0] words_in;
  logic [BITS-1:0]       lane_out;
  logic                  frame_sync;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  hitword_lane_serializer #(.WORDS(WORDS), .BITS(BITS)) dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .words_in(words_in),
    .lane_out(lane_out), .frame_sync(frame_sync)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Word j of frame f, computed arithmetically
  function automatic logic [BITS-1:0] pat(input int f, input int j);
    if (f == 0) return '1;
    if (f == 1) return BITS'(1) << (j % BITS);
    if (f == 2) return '0;
    return BITS'((f * 1103 + j * 2741 + f * j * 37) ^ (f << 5) ^ (j << 9));
  endfunction

  function automatic logic [WORDS*BITS-1:0] group(input int f);
    logic [WORDS*BITS-1:0] g;
    for (int j = 0; j < WORDS; j++) g[j*BITS +: BITS] = pat(f, j);
    return g;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [BITS-1:0] exp_l, input logic exp_s);
    checks++;
    if (lane_out !== exp_l || frame_sync !== exp_s) begin
      errors++;
      $display("FAIL %s lanes=%h expected %h sync=%b expected %b",
               req, lane_out, exp_l, frame_sync, exp_s);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL all: watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load_en = 1'b0; words_in = '0;
    #1;
    repeat (3) step();
    chk("R1 in reset", '0, 1'b0);
    rst_n = 1'b1;
    // R1: no load yet, outputs stay quiet (inputs toggling without load)
    for (int c = 0; c < 6; c++) begin
      words_in = group(c + 3);
      step();
      chk("R1 before first load", '0, 1'b0);
    end

    // R2 R3 R4 R5 R6: back-to-back frames, load every WORDS cycles
    load_en  = 1'b1;
    words_in = group(0);
    for (int f = 0; f < 40; f++) begin
      for (int j = 0; j < WORDS; j++) begin
        step();
        if (j == 0) chk("R2 R4 word0 with sync", pat(f, 0), 1'b1);
        else        chk("R3 R5 word order", pat(f, j), 1'b0);
        if (j == 0) begin
          load_en = 1'b0;
        end
        if (j < WORDS - 1 && !load_en) begin
          words_in = ~group(f + 50);  // R6: scramble between loads
        end
        if (j == WORDS - 1 && f < 39) begin
          load_en  = 1'b1;
          words_in = group(f + 1);
        end
      end
    end

    // R7: no further load, lanes drain to zero
    load_en  = 1'b0;
    words_in = '1;
    for (int c = 0; c < 5; c++) begin
      step();
      chk("R7 drained", '0, 1'b0);
    end

    // R8: early load restarts the frame
    load_en  = 1'b1;
    words_in = group(7);
    step();
    chk("R8 first group word0", pat(7, 0), 1'b1);
    load_en  = 1'b0;
    words_in = '0;
    step();
    chk("R8 first group word1", pat(7, 1), 1'b0);
    step();
    chk("R8 first group word2", pat(7, 2), 1'b0);
    load_en  = 1'b1;
    words_in = group(9);
    step();
    chk("R8 restart word0", pat(9, 0), 1'b1);
    load_en  = 1'b0;
    words_in = group(11);
    for (int j = 1; j < WORDS; j++) begin
      step();
      chk("R8 restart order", pat(9, j), 1'b0);
    end
    step();
    chk("R7 drained after restart", '0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule